// File: doc/BRIEF.md
# Zero-Crossing FSK Receiver with Carrier Qualification

This block recovers 1200-baud binary FSK data from a line signal that has already been filtered and hard-limited to a single bit. It measures each half-period of the incoming square wave in system clock cycles. A half-period near the 2200 Hz tone is read as space (logic 0), and one near the 1200 Hz tone is read as mark (logic 1). Any other interval is treated as invalid. A majority vote over the last three valid half-periods forms the data bit, so one corrupted half-cycle does not reach the output.

An active-low carrier flag qualifies the signal. It asserts only after an unbroken run of valid half-periods has lasted a set number of milliseconds. It releases once no valid half-period has been seen for a longer, separate interval. Both windows are timed with a prescaled tick derived from the clock frequency parameter. When the receiver is disabled or powered down, both outputs are driven high and all timing state is cleared. The data output is also held high whenever the carrier flag is inactive.

Top module: `fsk_line_demod`

## Requirements
- R1: Following reset, `carrier_n_o` reads 1 and `data_o` reads 1.
- R2: A half-period of at least 3/4 of the nominal space half-period, and shorter than the midpoint between the nominal space and mark half-periods, is classified as space and drives `data_o` to 0 while carrier is detected.
- R3: A half-period from that midpoint up to 5/4 of the nominal mark half-period is classified as mark and drives `data_o` to 1 while carrier is detected.
- R4: A half-period outside both ranges is invalid. It leaves `data_o` unchanged, and a stream of only invalid half-periods never asserts `carrier_n_o`.
- R5: `data_o` is the majority of the last three valid classifications, so a single opposite half-period inside a run does not change it.
- R6: `carrier_n_o` goes to 0 after an unbroken run of valid half-periods lasting QUAL_US microseconds, with one tick of granularity. The default of 5 ms lies inside the 2.5 to 10 ms window.
- R7: Once asserted, `carrier_n_o` returns to 1 after REL_US microseconds, with one tick of granularity, without a valid half-period. The default of 7.5 ms lies inside the 3.75 to 11.25 ms window. Invalid half-periods do not extend the carrier, and a valid half-period never releases it.
- R8: While `pwr_dn` is 1, both outputs read 1 in the same cycle. All qualification state is cleared, so the carrier is inactive once `pwr_dn` returns to 0.
- R9: While `rx_en` is 0, both outputs read 1 in the same cycle and the qualification state is cleared.
- R10: `data_o` reads 1 whenever the carrier is not detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_i | input | 1 | Hard-limited line signal |
| rx_en | input | 1 | Receive enable, active high |
| pwr_dn | input | 1 | Power-down request, active high |
| data_o | output | 1 | Demodulated data bit (1 = mark) |
| carrier_n_o | output | 1 | Carrier detected, active low |

## Verification
The bench builds the block with CLK_HZ set to 264000 and keeps the 4 kHz tick and the default millisecond windows. The nominal half-periods therefore become 60 and 110 cycles, and one tick becomes 66 cycles. With these values the complete qualify and release windows, the boundary checks just before and just after each edge, the glitch and invalid-interval cases, and the power-down and disable clearing can all be exercised within a few tens of thousands of cycles, with exact cycle bounds worked out from the requirements.

// File: rtl/fskd_pkg.sv
`timescale 1ns/1ps
package fskd_pkg;
  typedef enum logic [1:0] {
    CLS_BAD   = 2'd0,
    CLS_SPACE = 2'd1,
    CLS_MARK  = 2'd2
  } cls_e;
endpackage

// File: rtl/fskd_period_meter.sv
`timescale 1ns/1ps
module fskd_period_meter import fskd_pkg::*; #(
  parameter int CLK_HZ      = 3579545,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_HZ    = 2200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic line_i,
  output logic cls_vld_o,
  output cls_e cls_o
);
  localparam int SP_HALF = CLK_HZ / (2 * SPACE_HZ);
  localparam int MK_HALF = CLK_HZ / (2 * MARK_HZ);
  localparam int SP_LO   = SP_HALF - SP_HALF / 4;
  localparam int SPLIT   = (SP_HALF + MK_HALF) / 2;
  localparam int MK_HI   = MK_HALF + MK_HALF / 4;
  localparam int CNT_SAT = MK_HI + 1;
  localparam int CW      = $clog2(CNT_SAT + 1);
  localparam logic [CW-1:0] SP_LO_C = CW'(SP_LO);
  localparam logic [CW-1:0] SPLIT_C = CW'(SPLIT);
  localparam logic [CW-1:0] MK_HI_C = CW'(MK_HI);
  localparam logic [CW-1:0] SAT_C   = CW'(CNT_SAT);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   line_s, edge_w;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   armed_q, armed_d;
  logic                   vld_q, vld_d;
  cls_e                   cls_q, cls_d;

  function automatic cls_e classify(input logic [CW-1:0] n);
    if (n >= SP_LO_C && n < SPLIT_C)       classify = CLS_SPACE;
    else if (n >= SPLIT_C && n <= MK_HI_C) classify = CLS_MARK;
    else                                   classify = CLS_BAD;
  endfunction

  assign sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
  assign line_s = sync_q[SYNC_STAGES-1];
  assign edge_w = line_s ^ prev_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    vld_d   = 1'b0;
    cls_d   = cls_q;
    if (!active_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (edge_w) begin
      cnt_d   = CW'(1);
      armed_d = 1'b1;
      if (armed_q) begin
        vld_d = 1'b1;
        cls_d = classify(cnt_q);
      end
    end else if (cnt_q != SAT_C) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      cls_q   <= CLS_BAD;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= line_s;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      vld_q   <= vld_d;
      cls_q   <= cls_d;
    end
  end

  assign cls_vld_o = vld_q;
  assign cls_o     = cls_q;

  // Overlong intervals stay saturated until an edge, so they classify as invalid
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && cnt_q == SAT_C && !edge_w) |=> (cnt_q == SAT_C));
endmodule

// File: rtl/fskd_vote.sv
`timescale 1ns/1ps
module fskd_vote import fskd_pkg::*; #(
  parameter int VOTES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic cls_vld_i,
  input  cls_e cls_i,
  output logic data_o
);
  localparam int CW = $clog2(VOTES + 1);
  localparam logic [CW-1:0] HALF_C = CW'(VOTES / 2);

  logic [VOTES-1:0] hist_q, hist_d;
  logic             data_q, data_d;
  logic [CW-1:0]    ones;
  logic             take;

  assign take = cls_vld_i && (cls_i != CLS_BAD);

  always_comb begin
    hist_d = hist_q;
    if (!active_i)  hist_d = '1;
    else if (take)  hist_d = {hist_q[VOTES-2:0], (cls_i == CLS_MARK)};
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTES; i++) ones = ones + CW'(hist_d[i]);
  end

  always_comb begin
    data_d = data_q;
    if (!active_i || take) data_d = (ones > HALF_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      data_q <= 1'b1;
    end else begin
      hist_q <= hist_d;
      data_q <= data_d;
    end
  end

  assign data_o = data_q;

  // Data can move only when a valid classification arrives
  assert_vote_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !take) |=> $stable(data_q));
endmodule

// File: rtl/fskd_carrier.sv
`timescale 1ns/1ps
module fskd_carrier import fskd_pkg::*; #(
  parameter int CLK_HZ  = 3579545,
  parameter int TICK_HZ = 4000,
  parameter int QUAL_US = 5000,
  parameter int REL_US  = 7500,
  parameter int GAP_CYC = 1864
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic cls_vld_i,
  input  cls_e cls_i,
  output logic det_o
);
  localparam int TICK_CYC   = CLK_HZ / TICK_HZ;
  localparam int QUAL_TICKS = (QUAL_US * TICK_HZ) / 1000000;
  localparam int REL_TICKS  = (REL_US * TICK_HZ) / 1000000;
  localparam int GAP_TICKS  = (GAP_CYC + TICK_CYC - 1) / TICK_CYC + 1;
  localparam int PW = $clog2(TICK_CYC);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam int IW = $clog2(REL_TICKS + 1);
  localparam logic [PW-1:0] TICK_END = PW'(TICK_CYC - 1);
  localparam logic [QW-1:0] QUAL_C   = QW'(QUAL_TICKS);
  localparam logic [IW-1:0] REL_C    = IW'(REL_TICKS);
  localparam logic [IW-1:0] GAP_C    = IW'(GAP_TICKS);

  logic [PW-1:0] pre_q, pre_d;
  logic [QW-1:0] qual_q, qual_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          run_q, run_d;
  logic          det_q, det_d;
  logic          tick, good, bad;

  assign tick = (pre_q == TICK_END);
  assign good = cls_vld_i && (cls_i != CLS_BAD);
  assign bad  = cls_vld_i && (cls_i == CLS_BAD);

  always_comb begin
    pre_d  = '0;
    qual_d = '0;
    idle_d = '0;
    run_d  = 1'b0;
    det_d  = 1'b0;
    if (active_i) begin
      pre_d  = tick ? '0 : pre_q + PW'(1);
      run_d  = run_q;
      idle_d = idle_q;
      det_d  = det_q;
      if (good)                          begin idle_d = '0; run_d = 1'b1; end
      else if (tick && idle_q != REL_C)  idle_d = idle_q + IW'(1);
      if (bad)                           run_d = 1'b0;
      if (idle_d >= GAP_C)               run_d = 1'b0;
      if (!run_d)                        qual_d = '0;
      else if (tick && !det_q && qual_q != QUAL_C) qual_d = qual_q + QW'(1);
      else                               qual_d = qual_q;
      if (!det_q && qual_d == QUAL_C)    det_d = 1'b1;
      if (det_q && idle_d == REL_C)      det_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      qual_q <= '0;
      idle_q <= '0;
      run_q  <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      qual_q <= qual_d;
      idle_q <= idle_d;
      run_q  <= run_d;
      det_q  <= det_d;
    end
  end

  assign det_o = det_q;

  assert_qual_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q) |-> run_q);
  assert_valid_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && det_q && good) |=> det_q);
  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (!det_q && qual_q == '0 && !run_q));
endmodule

// File: rtl/fsk_line_demod.sv
`timescale 1ns/1ps
module fsk_line_demod import fskd_pkg::*; #(
  parameter int CLK_HZ      = 3579545,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_HZ    = 2200,
  parameter int TICK_HZ     = 4000,
  parameter int QUAL_US     = 5000,
  parameter int REL_US      = 7500,
  parameter int VOTES       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic rx_en,
  input  logic pwr_dn,
  output logic data_o,
  output logic carrier_n_o
);
  localparam int MK_HALF = CLK_HZ / (2 * MARK_HZ);
  localparam int MK_HI   = MK_HALF + MK_HALF / 4;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       active;
  logic       cls_vld;
  cls_e       cls;
  logic       vote_bit;
  logic       det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];
  assign active  = rx_en && !pwr_dn;

  fskd_period_meter #(
    .CLK_HZ(CLK_HZ), .MARK_HZ(MARK_HZ), .SPACE_HZ(SPACE_HZ), .SYNC_STAGES(SYNC_STAGES)
  ) u_meter (
    .clk(clk), .rst_n(rst_n_s), .active_i(active), .line_i(line_i),
    .cls_vld_o(cls_vld), .cls_o(cls)
  );

  fskd_vote #(.VOTES(VOTES)) u_vote (
    .clk(clk), .rst_n(rst_n_s), .active_i(active),
    .cls_vld_i(cls_vld), .cls_i(cls), .data_o(vote_bit)
  );

  fskd_carrier #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .QUAL_US(QUAL_US), .REL_US(REL_US), .GAP_CYC(MK_HI)
  ) u_carrier (
    .clk(clk), .rst_n(rst_n_s), .active_i(active),
    .cls_vld_i(cls_vld), .cls_i(cls), .det_o(det)
  );

  assign carrier_n_o = !(active && det);
  assign data_o      = !(active && det) || vote_bit;

  // An invalid classification never starts the carrier
  assert_bad_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (carrier_n_o && active && cls_vld && cls == CLS_BAD) |=> carrier_n_o);
endmodule

// File: tb/fsk_line_demod_test.sv
`timescale 1ns/1ps
module fsk_line_demod_test;
  localparam int CLK_HZ = 264000;
  localparam int SP = 60;
  localparam int MK = 110;

  logic clk = 1'b0;
  logic rst_n, line, rx_en, pwr_dn;
  logic data_o, carrier_n_o;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  typedef struct { logic exp; int due; string tag; } sb_t;
  sb_t sb_q[$];
  sb_t item;

  fsk_line_demod #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .line_i(line), .rx_en(rx_en), .pwr_dn(pwr_dn),
    .data_o(data_o), .carrier_n_o(carrier_n_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Monitor: pop expected data bits once their settle time is reached
  always @(negedge clk) begin
    if (sb_q.size() > 0 && cyc >= sb_q[0].due) begin
      item = sb_q.pop_front();
      chk(data_o, item.exp, item.tag);
    end
  end

  task automatic half(input int h);
    repeat (h) @(negedge clk);
    line = ~line;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // Driver: one bit, mark = two mark halves, space = four space halves
  task automatic tbit(input logic b, input bit check_it);
    sb_t e;
    if (b) begin half(MK); half(MK); end
    else   repeat (4) half(SP);
    if (check_it) begin
      e.exp = b; e.due = cyc + 6; e.tag = b ? "R3 mark bit" : "R2 space bit";
      sb_q.push_back(e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line = 1'b0; rx_en = 1'b1; pwr_dn = 1'b0;
    repeat (5) @(negedge clk);
    chk(carrier_n_o, 1'b1, "R1 carrier after reset");
    chk(data_o, 1'b1, "R1 data after reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R6: qualify with marks; first valid class at 220, detect in [1478,1544]
    repeat (13) half(MK);
    chk(carrier_n_o, 1'b1, "R6 not yet qualified at 1430");
    repeat (2) half(MK);
    chk(carrier_n_o, 1'b0, "R6 qualified by 1650");

    // R2/R3 scoreboard over a mixed pattern
    for (int i = 0; i < 24; i++) tbit(((i * 7 + 3) % 5) < 2, 1'b1);
    tbit(1'b1, 1'b0);
    settle();

    // R5 glitch inside marks
    half(MK); half(MK); half(SP); settle();
    chk(data_o, 1'b1, "R5 single space half in marks");
    half(MK);
    repeat (4) half(SP); settle();
    chk(data_o, 1'b0, "R2 spaces after glitch");
    half(MK); settle();
    chk(data_o, 1'b0, "R5 single mark half in spaces");
    half(SP); half(SP);
    // R4 invalid short half leaves data and carrier
    half(20); settle();
    chk(data_o, 1'b0, "R4 invalid half leaves data");
    chk(carrier_n_o, 1'b0, "R4 invalid half keeps carrier");
    half(SP);
    while (sb_q.size() > 0) @(negedge clk);

    // R7 release after silence; R10 data forced high afterwards
    repeat (1850) @(negedge clk);
    chk(carrier_n_o, 1'b0, "R7 held before release window");
    repeat (250) @(negedge clk);
    chk(carrier_n_o, 1'b1, "R7 released by 2100");
    chk(data_o, 1'b1, "R10 data high without carrier");

    // R4 invalid-only stream never qualifies
    repeat (60) half(30);
    chk(carrier_n_o, 1'b1, "R4 short intervals do not qualify");
    repeat (15) half(170);
    chk(carrier_n_o, 1'b1, "R4 long intervals do not qualify");

    // R7 invalid crossings do not hold the carrier
    repeat (16) half(MK);
    chk(carrier_n_o, 1'b0, "R6 requalified");
    repeat (80) half(30);
    chk(carrier_n_o, 1'b1, "R7 invalid crossings do not hold");

    // R8 power-down
    repeat (16) half(MK);
    chk(carrier_n_o, 1'b0, "R8 precondition carrier");
    @(negedge clk); pwr_dn = 1'b1; #1;
    chk(carrier_n_o, 1'b1, "R8 carrier forced high");
    chk(data_o, 1'b1, "R8 data forced high");
    repeat (4) @(negedge clk); pwr_dn = 1'b0;
    repeat (4) @(negedge clk);
    chk(carrier_n_o, 1'b1, "R8 state cleared");

    // R9 disable, with spaces so forced data is visible
    repeat (30) half(SP); settle();
    chk(carrier_n_o, 1'b0, "R9 precondition carrier on spaces");
    chk(data_o, 1'b0, "R2 data low on spaces");
    @(negedge clk); rx_en = 1'b0; #1;
    chk(carrier_n_o, 1'b1, "R9 carrier forced high");
    chk(data_o, 1'b1, "R9 data forced high");
    repeat (4) @(negedge clk); rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(carrier_n_o, 1'b1, "R9 state cleared");
    chk(data_o, 1'b1, "R10 data high after clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule